// File: doc/BRIEF.md
# Preemption Technique Cost Selector

When a higher-priority kernel needs a streaming multiprocessor, a running thread block has to give way. This block looks at the candidate thread blocks one at a time and prices three ways of removing each one. A context switch saves the state and restores it later. A drain lets the block run to completion. A flush discards the block's work and reruns the block later, and is only legal when the block's code is idempotent. Each way is priced by two costs: how long the preemption takes (latency, in cycles) and how much useful work is lost (overhead, in warp instructions).

Candidates are streamed in, one per clock, with a valid strobe and a last marker. The kernel-wide figures stay constant for the whole scan: average instructions per block, CPI, IPC, context size, total memory bandwidth, SM count and the latency limit. Among all (candidate, method) pairs whose latency is within the limit, the block picks the one with the smallest overhead. If no pair meets the limit, it picks the pair with the smallest latency and raises a violation flag. The result is reported with a one-cycle done pulse and then held. A scan holds at most `NCAND` candidates. A candidate's index is its position within the scan, starting at 0.

Top module: `preempt_cost_sel`

## Requirements
- R1: Switch latency is `ctx_bytes / (mem_bw / sm_count)` with integer division. When `sm_count` is 0 or the per-SM share is 0, it saturates to all ones of `COST_W` bits. It is also clamped to that value.
- R2: Drain latency is `max(avg_insts - cand_prog, 0) * cpi`, clamped to all ones of `COST_W` bits.
- R3: Flush latency is 0. Flush is a legal option only when `cand_idem` is 1.
- R4: Switch overhead is `2 * ipc * switch_latency`, clamped to all ones of `COST_W` bits.
- R5: Flush overhead is `cand_prog`. Drain overhead is `max(cand_sm_peak - cand_prog, 0)`, where `cand_sm_peak` is the progress of the most advanced block on the candidate's SM.
- R6: A pair is feasible when its latency is at most `lat_limit`. If any pair is feasible, the chosen pair is the feasible one with the smallest overhead, and `violation` is 0.
- R7: If no pair is feasible, the chosen pair is the one with the smallest latency among the legal pairs, and `violation` is 1.
- R8: Ties are broken first by the lower candidate index. Within one candidate the order is flush, then switch, then drain.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts the candidate with `cand_last` set. `victim_method` is encoded 2'b00 switch, 2'b01 drain, 2'b10 flush. `victim_idx`, `victim_method` and `violation` hold their values until the next done.
- R10: After reset, `done`, `victim_idx`, `victim_method` and `violation` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | A candidate is presented this cycle |
| cand_last | input | 1 | The presented candidate ends the scan |
| cand_prog | input | PROG_W | Warp instructions the candidate has executed |
| cand_idem | input | 1 | The candidate's code is idempotent |
| cand_sm_peak | input | PROG_W | Progress of the most advanced block on the same SM |
| avg_insts | input | PROG_W | Average warp instructions per block |
| cpi | input | RATE_W | Cycles per instruction |
| ipc | input | RATE_W | Instructions per cycle |
| ctx_bytes | input | CTX_W | Context size of one block in bytes |
| mem_bw | input | BW_W | Total memory bandwidth in bytes per cycle |
| sm_count | input | SMC_W | Number of SMs sharing the bandwidth |
| lat_limit | input | COST_W | Latency limit in cycles |
| done | output | 1 | One-cycle pulse when the result is ready |
| victim_idx | output | IDX_W | Index of the chosen candidate within the scan |
| victim_method | output | 2 | Chosen method code |
| violation | output | 1 | No pair met the latency limit |

## Verification
The done pulse and result update of one scan can fall in the same cycle as the first candidate of the next scan. In that cycle the running best must restart from that candidate, while the reported result still reflects only the previous scan. The bench provokes this by starting a second scan immediately after a last candidate, with no idle cycle between them. The scoreboard judges it in two ways: each done must arrive in the cycle after its own last candidate, and each done must carry that scan's independently computed choice. A stale best that leaked from the earlier scan would show up as a wrong index or method in the second result.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    M_SWITCH = 2'b00,
    M_DRAIN  = 2'b01,
    M_FLUSH  = 2'b10
  } meth_e;

  // difference clamped at zero, on a wide intermediate
  function automatic logic [63:0] floor_sub(input logic [63:0] a, input logic [63:0] b);
    return (a > b) ? (a - b) : 64'd0;
  endfunction

endpackage

// File: rtl/pcs_cost_unit.sv
module pcs_cost_unit
  import pcs_pkg::*;
#(
  parameter int PROG_W = 16,
  parameter int RATE_W = 8,
  parameter int CTX_W  = 24,
  parameter int BW_W   = 16,
  parameter int SMC_W  = 6,
  parameter int COST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [PROG_W-1:0] prog,
  input  logic              idem,
  input  logic [PROG_W-1:0] sm_peak,
  input  logic [PROG_W-1:0] avg_insts,
  input  logic [RATE_W-1:0] cpi,
  input  logic [RATE_W-1:0] ipc,
  input  logic [CTX_W-1:0]  ctx_bytes,
  input  logic [BW_W-1:0]   mem_bw,
  input  logic [SMC_W-1:0]  sm_count,
  input  logic [COST_W-1:0] lat_limit,
  output logic              f_found,
  output meth_e             f_meth,
  output logic [COST_W-1:0] f_ovh,
  output logic [COST_W-1:0] f_lat,
  output meth_e             l_meth,
  output logic [COST_W-1:0] l_lat
);

  localparam int          NOPT = 3;
  localparam logic [63:0] MAXC = (64'd1 << COST_W) - 64'd1;

  function automatic logic [COST_W-1:0] clamp(input logic [63:0] v);
    return (v > MAXC) ? MAXC[COST_W-1:0] : v[COST_W-1:0];
  endfunction

  function automatic logic [COST_W-1:0] switch_lat(input logic [63:0] ctx,
                                                   input logic [63:0] bw,
                                                   input logic [63:0] smc);
    logic [63:0] share;
    share = (smc == 64'd0) ? 64'd0 : (bw / smc);
    return (share == 64'd0) ? MAXC[COST_W-1:0] : clamp(ctx / share);
  endfunction

  function automatic logic [COST_W-1:0] drain_lat(input logic [63:0] avg,
                                                  input logic [63:0] done_i,
                                                  input logic [63:0] c);
    return clamp(floor_sub(avg, done_i) * c);
  endfunction

  function automatic logic [COST_W-1:0] switch_ovh(input logic [63:0] rate,
                                                   input logic [COST_W-1:0] lat);
    return clamp(64'd2 * rate * 64'(lat));
  endfunction

  // options listed in tie priority order: flush, switch, drain
  meth_e             opt_m   [NOPT];
  logic              opt_ok  [NOPT];
  logic [COST_W-1:0] opt_lat [NOPT];
  logic [COST_W-1:0] opt_ovh [NOPT];
  logic [COST_W-1:0] sw_lat_w;

  assign sw_lat_w = switch_lat(64'(ctx_bytes), 64'(mem_bw), 64'(sm_count));

  always_comb begin
    opt_m[0]   = M_FLUSH;
    opt_ok[0]  = idem;
    opt_lat[0] = '0;
    opt_ovh[0] = clamp(64'(prog));
    opt_m[1]   = M_SWITCH;
    opt_ok[1]  = 1'b1;
    opt_lat[1] = sw_lat_w;
    opt_ovh[1] = switch_ovh(64'(ipc), sw_lat_w);
    opt_m[2]   = M_DRAIN;
    opt_ok[2]  = 1'b1;
    opt_lat[2] = drain_lat(64'(avg_insts), 64'(prog), 64'(cpi));
    opt_ovh[2] = clamp(floor_sub(64'(sm_peak), 64'(prog)));
  end

  logic l_found;

  always_comb begin
    f_found = 1'b0;
    f_meth  = M_SWITCH;
    f_ovh   = '0;
    f_lat   = '0;
    l_found = 1'b0;
    l_meth  = M_SWITCH;
    l_lat   = '0;
    for (int k = 0; k < NOPT; k++) begin
      if (opt_ok[k] && (opt_lat[k] <= lat_limit) && (!f_found || (opt_ovh[k] < f_ovh))) begin
        f_found = 1'b1;
        f_meth  = opt_m[k];
        f_ovh   = opt_ovh[k];
        f_lat   = opt_lat[k];
      end
      if (opt_ok[k] && (!l_found || (opt_lat[k] < l_lat))) begin
        l_found = 1'b1;
        l_meth  = opt_m[k];
        l_lat   = opt_lat[k];
      end
    end
  end

  // R3
  flush_idem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && ((f_found && f_meth == M_FLUSH) || l_meth == M_FLUSH)) |-> idem);

  // R3
  idem_feasible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && idem) |-> f_found);

  // R6
  feas_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && f_found) |-> (f_lat <= lat_limit));

endmodule

// File: rtl/pcs_tracker.sv
module pcs_tracker
  import pcs_pkg::*;
#(
  parameter int NCAND  = 8,
  parameter int COST_W = 32,
  localparam int IDX_W = (NCAND > 1) ? $clog2(NCAND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic              cand_last,
  input  logic [COST_W-1:0] lat_limit,
  input  logic              u_f_found,
  input  meth_e             u_f_meth,
  input  logic [COST_W-1:0] u_f_ovh,
  input  logic [COST_W-1:0] u_f_lat,
  input  meth_e             u_l_meth,
  input  logic [COST_W-1:0] u_l_lat,
  output logic              done,
  output logic [IDX_W-1:0]  victim_idx,
  output logic [1:0]        victim_method,
  output logic              violation
);

  logic [IDX_W-1:0]  idx_q;
  logic              fh_q;
  logic [COST_W-1:0] f_ovh_q, f_lat_q, l_lat_q;
  logic [IDX_W-1:0]  f_idx_q, l_idx_q;
  meth_e             f_m_q, l_m_q;

  logic              fresh;
  logic              n_fh;
  logic [COST_W-1:0] n_f_ovh, n_f_lat, n_l_lat;
  logic [IDX_W-1:0]  n_f_idx, n_l_idx;
  meth_e             n_f_m, n_l_m;
  logic              take_f, take_l;
  logic              nxt_viol;
  logic [IDX_W-1:0]  nxt_idx;
  meth_e             nxt_m;
  logic [COST_W-1:0] nxt_lat;

  assign fresh = (idx_q == '0);
  // strict comparisons keep earlier (lower index) holders on ties
  assign take_f = u_f_found && (fresh || !fh_q || (u_f_ovh < f_ovh_q));
  assign take_l = fresh || (u_l_lat < l_lat_q);

  always_comb begin
    n_fh    = fresh ? 1'b0 : fh_q;
    n_f_ovh = f_ovh_q;
    n_f_lat = f_lat_q;
    n_f_idx = f_idx_q;
    n_f_m   = f_m_q;
    if (take_f) begin
      n_fh    = 1'b1;
      n_f_ovh = u_f_ovh;
      n_f_lat = u_f_lat;
      n_f_idx = idx_q;
      n_f_m   = u_f_meth;
    end
    n_l_lat = take_l ? u_l_lat  : l_lat_q;
    n_l_idx = take_l ? idx_q    : l_idx_q;
    n_l_m   = take_l ? u_l_meth : l_m_q;
  end

  assign nxt_viol = !n_fh;
  assign nxt_idx  = n_fh ? n_f_idx : n_l_idx;
  assign nxt_m    = n_fh ? n_f_m   : n_l_m;
  assign nxt_lat  = n_fh ? n_f_lat : n_l_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      fh_q    <= 1'b0;
      f_ovh_q <= '0;
      f_lat_q <= '0;
      f_idx_q <= '0;
      f_m_q   <= M_SWITCH;
      l_lat_q <= '0;
      l_idx_q <= '0;
      l_m_q   <= M_SWITCH;
    end else if (cand_valid) begin
      idx_q   <= cand_last ? '0 : idx_q + 1'b1;
      fh_q    <= n_fh;
      f_ovh_q <= n_f_ovh;
      f_lat_q <= n_f_lat;
      f_idx_q <= n_f_idx;
      f_m_q   <= n_f_m;
      l_lat_q <= n_l_lat;
      l_idx_q <= n_l_idx;
      l_m_q   <= n_l_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done          <= 1'b0;
      victim_idx    <= '0;
      victim_method <= 2'b00;
      violation     <= 1'b0;
    end else begin
      done <= cand_valid && cand_last;
      if (cand_valid && cand_last) begin
        victim_idx    <= nxt_idx;
        victim_method <= nxt_m;
        violation     <= nxt_viol;
      end
    end
  end

  // R6
  pick_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_last && !nxt_viol) |-> (nxt_lat <= lat_limit));

  // R7
  viol_none_feas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_last && nxt_viol) |-> !u_f_found);

  // R9
  method_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (victim_method != 2'b11));

  // R9
  idx_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (victim_idx <= $past(idx_q)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(victim_idx) || done));

endmodule

// File: rtl/preempt_cost_sel.sv
module preempt_cost_sel
  import pcs_pkg::*;
#(
  parameter int NCAND  = 8,
  parameter int PROG_W = 16,
  parameter int RATE_W = 8,
  parameter int CTX_W  = 24,
  parameter int BW_W   = 16,
  parameter int SMC_W  = 6,
  parameter int COST_W = 32,
  localparam int IDX_W = (NCAND > 1) ? $clog2(NCAND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic              cand_last,
  input  logic [PROG_W-1:0] cand_prog,
  input  logic              cand_idem,
  input  logic [PROG_W-1:0] cand_sm_peak,
  input  logic [PROG_W-1:0] avg_insts,
  input  logic [RATE_W-1:0] cpi,
  input  logic [RATE_W-1:0] ipc,
  input  logic [CTX_W-1:0]  ctx_bytes,
  input  logic [BW_W-1:0]   mem_bw,
  input  logic [SMC_W-1:0]  sm_count,
  input  logic [COST_W-1:0] lat_limit,
  output logic              done,
  output logic [IDX_W-1:0]  victim_idx,
  output logic [1:0]        victim_method,
  output logic              violation
);

  logic              u_f_found;
  meth_e             u_f_meth, u_l_meth;
  logic [COST_W-1:0] u_f_ovh, u_f_lat, u_l_lat;

  pcs_cost_unit #(
    .PROG_W(PROG_W), .RATE_W(RATE_W), .CTX_W(CTX_W),
    .BW_W(BW_W), .SMC_W(SMC_W), .COST_W(COST_W)
  ) u_cost (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (cand_valid),
    .prog      (cand_prog),
    .idem      (cand_idem),
    .sm_peak   (cand_sm_peak),
    .avg_insts (avg_insts),
    .cpi       (cpi),
    .ipc       (ipc),
    .ctx_bytes (ctx_bytes),
    .mem_bw    (mem_bw),
    .sm_count  (sm_count),
    .lat_limit (lat_limit),
    .f_found   (u_f_found),
    .f_meth    (u_f_meth),
    .f_ovh     (u_f_ovh),
    .f_lat     (u_f_lat),
    .l_meth    (u_l_meth),
    .l_lat     (u_l_lat)
  );

  pcs_tracker #(
    .NCAND(NCAND), .COST_W(COST_W)
  ) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .cand_valid    (cand_valid),
    .cand_last     (cand_last),
    .lat_limit     (lat_limit),
    .u_f_found     (u_f_found),
    .u_f_meth      (u_f_meth),
    .u_f_ovh       (u_f_ovh),
    .u_f_lat       (u_f_lat),
    .u_l_meth      (u_l_meth),
    .u_l_lat       (u_l_lat),
    .done          (done),
    .victim_idx    (victim_idx),
    .victim_method (victim_method),
    .violation     (violation)
  );

endmodule

// File: tb/sim_preempt_cost_sel.sv
`timescale 1ns/1ps
module sim_preempt_cost_sel;

  localparam int NC = 8;
  localparam longint MAXC = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0, cand_last = 1'b0, cand_idem = 1'b0;
  logic [15:0] cand_prog = '0, cand_sm_peak = '0, avg_insts = '0;
  logic [7:0]  cpi = '0, ipc = '0;
  logic [23:0] ctx_bytes = '0;
  logic [15:0] mem_bw = '0;
  logic [5:0]  sm_count = '0;
  logic [31:0] lat_limit = '0;
  logic        done, violation;
  logic [2:0]  victim_idx;
  logic [1:0]  victim_method;

  always #2.5 clk = ~clk;

  preempt_cost_sel u0 (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_last(cand_last),
    .cand_prog(cand_prog), .cand_idem(cand_idem), .cand_sm_peak(cand_sm_peak),
    .avg_insts(avg_insts), .cpi(cpi), .ipc(ipc), .ctx_bytes(ctx_bytes),
    .mem_bw(mem_bw), .sm_count(sm_count), .lat_limit(lat_limit),
    .done(done), .victim_idx(victim_idx), .victim_method(victim_method),
    .violation(violation)
  );

  typedef struct {
    int     idx;
    int     meth;
    int     viol;
    longint cyc;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int     prg[NC];
  bit     idm[NC];
  int     pk[NC];
  exp_t   last_exp;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint clampc(input longint v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  // independent cost model, R1..R8
  function automatic void cost(input int i, input int m, output bit ok, output longint lat,
                               output longint ovh);
    longint share, sw;
    share = (sm_count == 0) ? 0 : longint'(mem_bw) / longint'(sm_count);
    sw = (share == 0) ? MAXC : clampc(longint'(ctx_bytes) / share);
    ok = 1;
    case (m)
      2: begin ok = idm[i]; lat = 0; ovh = prg[i]; end
      0: begin lat = sw; ovh = clampc(2 * longint'(ipc) * sw); end
      default: begin
        lat = clampc(((avg_insts > prg[i]) ? longint'(avg_insts) - prg[i] : 0) * longint'(cpi));
        ovh = (pk[i] > prg[i]) ? pk[i] - prg[i] : 0;
      end
    endcase
  endfunction

  function automatic exp_t model(input int n);
    exp_t   e;
    int     order[3] = '{2, 0, 1};
    bit     fh = 0, lh = 0;
    longint fo = 0, ll = 0;
    int     fi = 0, fm = 0, li = 0, lm = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3; k++) begin
        bit ok; longint lat, ovh;
        cost(i, order[k], ok, lat, ovh);
        if (ok && lat <= longint'(lat_limit) && (!fh || ovh < fo)) begin
          fh = 1; fo = ovh; fi = i; fm = order[k];
        end
        if (ok && (!lh || lat < ll)) begin
          lh = 1; ll = lat; li = i; lm = order[k];
        end
      end
    end
    e.idx = fh ? fi : li;
    e.meth = fh ? fm : lm;
    e.viol = fh ? 0 : 1;
    return e;
  endfunction

  task automatic run_scan(input int n, input string tag);
    exp_t e;
    e = model(n);
    e.tag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cand_valid = 1'b1;
      cand_last = (i == n - 1);
      cand_prog = 16'(prg[i]);
      cand_idem = idm[i];
      cand_sm_peak = 16'(pk[i]);
      if (i == n - 1) begin
        e.cyc = cyc + 1;
        sb.push_back(e);
        last_exp = e;
      end
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cand_valid = 1'b0;
      cand_last = 1'b0;
    end
  endtask

  task automatic set_cfg(input int a, input int c, input int p, input int cx,
                         input int bw, input int sm, input longint lim);
    avg_insts = 16'(a); cpi = 8'(c); ipc = 8'(p); ctx_bytes = 24'(cx);
    mem_bw = 16'(bw); sm_count = 6'(sm); lat_limit = 32'(lim);
  endtask

  task automatic cand(input int i, input int p, input bit id, input int peak);
    prg[i] = p; idm[i] = id; pk[i] = peak;
  endtask

  // monitor: pops the scoreboard on each done
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) begin
          check(0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.cyc, {e.tag, " R9 done timing"}, cyc, e.cyc);
          check(int'(victim_idx) == e.idx, {e.tag, " R8 victim_idx"}, victim_idx, e.idx);
          check(int'(victim_method) == e.meth, {e.tag, " R6 victim_method"}, victim_method, e.meth);
          check(int'(violation) == e.viol, {e.tag, " R7 violation"}, violation, e.viol);
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0, "R10 done after reset", done, 0);
    check(victim_idx == 0 && victim_method == 0 && violation == 0,
          "R10 outputs after reset", {victim_idx, victim_method, violation}, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R4: switch lat 40, ovh 80; drain lat 1800 over limit
    set_cfg(1000, 2, 1, 400, 40, 4, 100);
    cand(0, 100, 0, 100);
    run_scan(1, "R1/R4 switch");
    idle(2);
    // R2 R5: drain lat 20, ovh 0
    cand(0, 990, 0, 990);
    run_scan(1, "R2/R5 drain");
    idle(2);
    // R3 R5: idempotent early block flushed
    cand(0, 10, 1, 10);
    run_scan(1, "R3 flush");
    idle(2);
    // R3: same block without idempotence falls back to switch
    cand(0, 10, 0, 10);
    run_scan(1, "R3 no flush");
    idle(2);
    // R8: flush ovh 80 equals switch ovh 80, two identical candidates
    cand(0, 80, 1, 80);
    cand(1, 80, 1, 80);
    run_scan(2, "R8 tie");
    idle(2);
    // R7: nothing within 5 cycles, candidate 1 drains in 10
    set_cfg(1000, 2, 1, 400, 40, 4, 5);
    cand(0, 100, 0, 100);
    cand(1, 995, 0, 995);
    run_scan(2, "R7 min latency");
    idle(2);
    // R1 saturation: sm_count 0, drain 2000 over limit 1000
    set_cfg(1000, 2, 1, 400, 40, 0, 1000);
    cand(0, 0, 0, 0);
    run_scan(1, "R1 zero share");
    idle(4);
    // R9 hold: outputs stay after done
    check(int'(victim_method) == last_exp.meth && int'(victim_idx) == last_exp.idx &&
          int'(violation) == last_exp.viol, "R9 hold",
          victim_method, last_exp.meth);
    // R8 R6: full scan, later candidate strictly cheaper
    set_cfg(1000, 2, 1, 400, 40, 4, 100);
    for (int i = 0; i < NC; i++) cand(i, 50 + i, 0, 50 + i);
    cand(5, 30, 1, 60);
    cand(6, 30, 1, 60);
    run_scan(NC, "R6 full scan");
    // back-to-back scans, no idle in between
    cand(0, 990, 0, 995);
    cand(1, 20, 1, 20);
    run_scan(2, "R9 back-to-back A");
    cand(0, 100, 0, 100);
    run_scan(1, "R9 back-to-back B");
    idle(2);

    // randomized scans
    for (int s = 0; s < 80; s++) begin
      int n;
      n = $urandom_range(1, NC);
      set_cfg($urandom_range(0, 4000), $urandom_range(0, 8), $urandom_range(0, 255),
              $urandom_range(0, 16777215), $urandom_range(0, 4000),
              ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 63),
              $urandom_range(0, 20000));
      for (int i = 0; i < n; i++)
        cand(i, $urandom_range(0, 4000), 1'($urandom_range(0, 1)), $urandom_range(0, 4000));
      run_scan(n, "R6/R7/R8 random");
      idle($urandom_range(1, 2));
    end

    idle(4);
    check(sb.size() == 0, "R9 all results seen", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule